// File: doc/BRIEF.md
# Loadable Four-Channel Clock Divider Bank

The bank derives four independent clock-enable streams from a single fast source clock. Each channel emits a pulse one source cycle wide once every N source cycles, where N is that channel's active ratio. Software programs the bank through a small register bus with two 32-bit words. The word at byte offset 0 holds, for each channel, a 6-bit ratio code and a load strobe. The word at byte offset 4 holds a global run bit (an active-high release from reset) and four sticky error flags.

A ratio code that is written to the register has no effect on its own. The channel captures the code only on a rising edge of its load strobe, and only while the run bit is set. The captured ratio waits in a pending slot until the channel's current output period completes, so the output never produces a shortened period. Channel 0 translates its code through a fixed scrambled table. Channels 1 to 3 use the code directly as the ratio. A code that is not legal leaves the ratio unchanged and sets that channel's error flag.

Each channel runs a three-state machine with the states HALT, RUN and ARMED:
- HALT→RUN happens when the run bit is set.
- RUN→ARMED happens on a load edge that carries a valid code.
- ARMED→ARMED happens on a further valid load edge, which replaces the pending ratio.
- ARMED→RUN happens at the period boundary, when the pending ratio becomes active.
- Any state→HALT happens when the run bit is clear.

Top module: `clkdiv_bank`

## Requirements
- R1: After rst_n is released, every tick output is low, and both control words read 0.
- R2: Word 0 (address bit 2 = 0) reads back exactly the written bits 1..28 and reads 0 in bits 0 and 29..31. Word 1 (address bit 2 = 1) reads the run bit at bit 10 and the error flags of channels 0..3 at bits 0..3, and reads 0 in every other bit.
- R3: Once the run bit is set, each channel whose ratio has not been loaded pulses its tick on every source cycle (ratio 1).
- R4: Writing a code to word 0 does not change the ratio while the channel's load strobe stays clear. The code is captured only on a 0→1 transition of the strobe. Strobe bit positions are 7, 14, 21 and 28 for channels 0..3.
- R5: Channels 1..3 take their code, held at bits 8..13, 15..20 and 22..27, directly as the tick period. Legal codes are 1..63.
- R6: Channel 0 takes its code from bits 1..6 and maps it to a period as follows: 1→2, 2→1, 3→3, 4→4, 5→6, 6→5, 7→7, 8→8, 9→10, 10→9.
- R7: A load of code 0 on any channel, or of a code of 11 or more on channel 0, keeps that channel's previous period. It also sets that channel's sticky error flag in word 1. The flag stays set until the run bit is cleared.
- R8: While the run bit is clear, every tick is low, load strobes are ignored, and the error flags are cleared. Re-enabling the bank starts every channel at ratio 1.
- R9: A newly captured ratio takes effect only after the current output period has completed at the old ratio.
- R10: Loading one channel does not alter the period of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | 3 | Byte address; bit 2 selects word 1 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| tick_o | output | 4 | Per-channel divided clock-enable pulses |

## Verification
A corrupted active ratio, pending ratio or counter changes the spacing of a channel's tick pulses. The error appears within one period, which is at most 63 source cycles, so the bench measures intervals between ticks rather than single pulses. A wrong machine state shows as one of three symptoms:
- a missing tick;
- a ratio applied in the middle of a period, which shortens the interval seen across a load;
- ticks that continue after the run bit has been cleared.

A wrong decision about the validity of a code shows in word 1 on the cycle after the load edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        CH_HALT  = 2'd0,
        CH_RUN   = 2'd1,
        CH_ARMED = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] ratio;
    } ratio_dec_t;

    // Code-to-ratio translation; scrambled table or direct binary.
    function automatic ratio_dec_t decode_code(input logic [7:0] code,
                                               input logic       use_table);
        ratio_dec_t r;
        r.valid = 1'b1;
        r.ratio = code;
        if (use_table) begin
            case (code)
                8'd1:    r.ratio = 8'd2;
                8'd2:    r.ratio = 8'd1;
                8'd3:    r.ratio = 8'd3;
                8'd4:    r.ratio = 8'd4;
                8'd5:    r.ratio = 8'd6;
                8'd6:    r.ratio = 8'd5;
                8'd7:    r.ratio = 8'd7;
                8'd8:    r.ratio = 8'd8;
                8'd9:    r.ratio = 8'd10;
                8'd10:   r.ratio = 8'd9;
                default: begin
                    r.valid = 1'b0;
                    r.ratio = 8'd1;
                end
            endcase
        end else begin
            r.valid = (code != 8'd0);
        end
        return r;
    endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
    parameter int NUM_CH     = 4,
    parameter int FIELD_W    = 6,
    parameter int FIELD_LSB0 = 1,
    parameter int CH_STRIDE  = 7,
    parameter int RUN_BIT    = 10,
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [DATA_W-1:0]               wdata_i,
    output logic [DATA_W-1:0]               rdata_o,
    output logic                            run_o,
    output logic [NUM_CH-1:0][FIELD_W-1:0]  codes_o,
    output logic [NUM_CH-1:0]               load_rise_o,
    output logic [NUM_CH-1:0]               err_o,
    input  logic [NUM_CH-1:0]               err_set_i
);

    localparam int SEL_BIT = 2;

    function automatic logic [DATA_W-1:0] word0_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int b = 0; b <= FIELD_W; b++) begin
                m[FIELD_LSB0 + c*CH_STRIDE + b] = 1'b1;
            end
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] W0_MASK = word0_mask();

    logic [DATA_W-1:0] word0_q;
    logic              run_q;
    logic [NUM_CH-1:0] err_q;
    logic [NUM_CH-1:0] load_now;
    logic [NUM_CH-1:0] load_prev_q;

    // Word storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word0_q <= '0;
            run_q   <= 1'b0;
        end else if (wr_i) begin
            if (addr_i[SEL_BIT]) begin
                run_q <= wdata_i[RUN_BIT];
            end else begin
                word0_q <= wdata_i & W0_MASK;
            end
        end
    end

    // Per-channel field extraction and strobe edge detection
    for (genvar c = 0; c < NUM_CH; c++) begin : g_fields
        localparam int LSB = FIELD_LSB0 + c*CH_STRIDE;
        assign codes_o[c]  = word0_q[LSB +: FIELD_W];
        assign load_now[c] = word0_q[LSB + FIELD_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_prev_q <= '0;
        end else begin
            load_prev_q <= load_now;
        end
    end

    assign load_rise_o = run_q ? (load_now & ~load_prev_q) : '0;

    // Sticky error flags, cleared while the bank is stopped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0;
        end else if (!run_q) begin
            err_q <= '0;
        end else begin
            err_q <= err_q | err_set_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i[SEL_BIT]) begin
            rdata_o[NUM_CH-1:0] = err_q;
            rdata_o[RUN_BIT]    = run_q;
        end else begin
            rdata_o = word0_q;
        end
    end

    assign run_o = run_q;
    assign err_o = err_q;

endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan #(
    parameter int   FIELD_W   = 6,
    parameter logic USE_TABLE = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               load_rise_i,
    input  logic [FIELD_W-1:0] code_i,
    output logic               tick_o,
    output logic               err_set_o,
    output logic [FIELD_W-1:0] act_o,
    output logic               armed_o
);
    import clkdiv_pkg::*;

    localparam logic [FIELD_W-1:0] RATIO_ONE = FIELD_W'(1);

    ch_state_e        state_q, state_d;
    logic [FIELD_W-1:0] act_q, pend_q, cnt_q;
    ratio_dec_t       dec;
    logic             load_ok;
    logic             boundary;

    assign dec      = decode_code(8'(code_i), USE_TABLE);
    assign load_ok  = load_rise_i && dec.valid;
    assign boundary = (cnt_q == act_q - RATIO_ONE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!run_i) begin
            state_d = CH_HALT;
        end else begin
            unique case (state_q)
                CH_HALT:  state_d = CH_RUN;
                CH_RUN:   if (load_ok) state_d = CH_ARMED;
                CH_ARMED: begin
                    if (load_ok)       state_d = CH_ARMED;
                    else if (boundary) state_d = CH_RUN;
                end
                default:  state_d = CH_HALT;
            endcase
        end
    end

    // Datapath: period counter, active and pending ratios
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            act_q  <= RATIO_ONE;
            pend_q <= RATIO_ONE;
        end else if (!run_i || state_q == CH_HALT) begin
            cnt_q  <= '0;
            act_q  <= RATIO_ONE;
            pend_q <= RATIO_ONE;
        end else begin
            cnt_q <= boundary ? '0 : cnt_q + RATIO_ONE;
            if (state_q == CH_ARMED && boundary) begin
                act_q <= pend_q;
            end
            if (load_ok) begin
                pend_q <= dec.ratio[FIELD_W-1:0];
            end
        end
    end

    // Outputs
    always_comb begin
        tick_o    = run_i && (state_q != CH_HALT) && boundary;
        err_set_o = load_rise_i && !dec.valid;
        act_o     = act_q;
        armed_o   = (state_q == CH_ARMED);
    end

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
    parameter int NUM_CH     = 4,
    parameter int FIELD_W    = 6,
    parameter int FIELD_LSB0 = 1,
    parameter int CH_STRIDE  = 7,
    parameter int RUN_BIT    = 10,
    parameter int TABLE_CH   = 0,
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [3:0]        tick_o
);

    logic                           run_w;
    logic [NUM_CH-1:0][FIELD_W-1:0] codes_w;
    logic [NUM_CH-1:0]              load_rise_w;
    logic [NUM_CH-1:0]              err_w;
    logic [NUM_CH-1:0]              err_set_w;
    logic [NUM_CH-1:0][FIELD_W-1:0] act_w;
    logic [NUM_CH-1:0]              armed_w;
    logic [NUM_CH-1:0]              tick_w;

    clkdiv_regs #(
        .NUM_CH(NUM_CH), .FIELD_W(FIELD_W), .FIELD_LSB0(FIELD_LSB0),
        .CH_STRIDE(CH_STRIDE), .RUN_BIT(RUN_BIT),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .rdata_o    (reg_rdata),
        .run_o      (run_w),
        .codes_o    (codes_w),
        .load_rise_o(load_rise_w),
        .err_o      (err_w),
        .err_set_i  (err_set_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        clkdiv_chan #(
            .FIELD_W  (FIELD_W),
            .USE_TABLE(c == TABLE_CH)
        ) chan_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .run_i      (run_w),
            .load_rise_i(load_rise_w[c]),
            .code_i     (codes_w[c]),
            .tick_o     (tick_w[c]),
            .err_set_o  (err_set_w[c]),
            .act_o      (act_w[c]),
            .armed_o    (armed_w[c])
        );
    end

    assign tick_o = 4'(tick_w);

endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
    parameter int NUM_CH   = 4,
    parameter int FIELD_W  = 6,
    parameter int TABLE_CH = 0
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           run_i,
    input logic [NUM_CH-1:0]              tick_i,
    input logic [NUM_CH-1:0]              err_i,
    input logic [NUM_CH-1:0][FIELD_W-1:0] act_i,
    input logic [NUM_CH-1:0]              armed_i
);

    // R8: stopped bank emits no ticks
    a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> (tick_i == '0));

    // R7: error flags never drop while running
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> (!run_i || ((err_i & $past(err_i)) == $past(err_i))));

    // R8: flags clear one cycle after the bank stops
    a_r8_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (err_i == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R9: active ratio frozen until the armed period ends
        a_r9_hold_until_edge: assert property (@(posedge clk) disable iff (!rst_n)
            (run_i && armed_i[c] && !tick_i[c]) |=> $stable(act_i[c]));

        // R5: active ratio is never zero
        a_r5_ratio_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
            act_i[c] != '0);

        if (c == TABLE_CH) begin : g_tbl
            // R6: table channel never exceeds its largest entry
            a_r6_table_range: assert property (@(posedge clk) disable iff (!rst_n)
                act_i[c] <= FIELD_W'(10));
        end
    end

endmodule

bind clkdiv_bank clkdiv_bank_chk #(
    .NUM_CH(NUM_CH), .FIELD_W(FIELD_W), .TABLE_CH(TABLE_CH)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_w),
    .tick_i (tick_w),
    .err_i  (err_w),
    .act_i  (act_w),
    .armed_i(armed_w)
);

// File: tb/clkdiv_bank_tb.sv
module clkdiv_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  tick_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [31:0] shadow0 = '0;

    typedef struct {
        int    ch;
        int    exp;
        string tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #5 clk = ~clk;

    clkdiv_bank dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_o(tick_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    // Load sequence: field with strobe clear, strobe set, hold, strobe clear
    task automatic load_ch(input int ch, input int code);
        int lsb;
        lsb = 1 + 7*ch;
        shadow0 = shadow0 & ~(32'h3F << lsb);
        shadow0 = shadow0 | (32'(code) << lsb);
        wr(3'd0, shadow0);
        wr(3'd0, shadow0 | (32'h1 << (lsb + 6)));
        repeat (25) @(negedge clk);
        wr(3'd0, shadow0);
        repeat (70) @(negedge clk);
    endtask

    // Driver side of the scoreboard
    task automatic expect_period(input int ch, input int exp, input string tag);
        exp_item_t it;
        it.ch = ch; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic quiet_window(input int cycles, input string tag);
        int seen;
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (tick_o != 4'h0) seen++;
        end
        check(tag, seen, 0);
    endtask

    // Monitor: measure the interval between two ticks of the requested channel
    initial begin
        forever begin
            exp_item_t it;
            int cnt;
            wait (sb_q.size() != 0);
            it = sb_q[0];
            cnt = 0;
            do @(negedge clk); while (!tick_o[it.ch]);
            do begin
                @(negedge clk);
                cnt++;
            end while (!tick_o[it.ch] && cnt < 200);
            check(it.tag, cnt, it.exp);
            void'(sb_q.pop_front());
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(10 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=complete");
        finish_run();
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 ticks after reset", tick_o, 0);
        rd(3'd0, 32'h0, "R1 word0 reset");
        rd(3'd4, 32'h0, "R1 word1 reset");
        quiet_window(10, "R1 no ticks before run");

        // R2: readback masks
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, 32'h1FFF_FFFE, "R2 word0 mask");
        wr(3'd0, 32'h0);
        shadow0 = 0;
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, 32'h0000_0400, "R2 word1 run bit");

        // R3: default ratio 1 on every channel
        for (int c = 0; c < 4; c++) expect_period(c, 1, $sformatf("R3 default ch%0d", c));

        // R4: field write without strobe has no effect
        shadow0 = shadow0 | (32'd5 << 8);
        wr(3'd0, shadow0);
        repeat (80) @(negedge clk);
        expect_period(1, 1, "R4 no strobe no change");
        rd(3'd0, shadow0, "R2 field readback");

        // R5: direct ratios
        load_ch(1, 5);
        expect_period(1, 5, "R5 ch1 ratio 5");
        load_ch(2, 63);
        expect_period(2, 63, "R5 ch2 ratio 63");
        load_ch(3, 17);
        expect_period(3, 17, "R5 ch3 ratio 17");

        // R6: table channel
        load_ch(0, 1);  expect_period(0, 2,  "R6 code1");
        load_ch(0, 2);  expect_period(0, 1,  "R6 code2");
        load_ch(0, 5);  expect_period(0, 6,  "R6 code5");
        load_ch(0, 6);  expect_period(0, 5,  "R6 code6");
        load_ch(0, 9);  expect_period(0, 10, "R6 code9");
        load_ch(0, 10); expect_period(0, 9,  "R6 code10");

        // R10: other channels untouched
        expect_period(1, 5,  "R10 ch1 kept");
        expect_period(3, 17, "R10 ch3 kept");
        expect_period(2, 63, "R10 ch2 kept");

        // R9: mid-period load completes the old period first
        load_ch(1, 40);
        expect_period(1, 40, "R9 ch1 ratio 40");
        do @(negedge clk); while (!tick_o[1]);
        shadow0 = shadow0 & ~(32'h3F << 8);
        shadow0 = shadow0 | (32'd3 << 8);
        wr(3'd0, shadow0 | (32'h1 << 14));
        cnt = 1;
        while (!tick_o[1] && cnt < 200) begin
            @(negedge clk);
            if (!tick_o[1]) cnt++;
            else cnt++;
            if (tick_o[1]) break;
        end
        check("R9 old period completes", cnt, 40);
        wr(3'd0, shadow0);
        expect_period(1, 3, "R9 new ratio after boundary");

        // R7: invalid codes
        load_ch(0, 11);
        expect_period(0, 9, "R7 ch0 keeps ratio");
        load_ch(3, 0);
        expect_period(3, 17, "R7 ch3 keeps ratio");
        rd(3'd4, 32'h0000_0409, "R7 sticky errors");

        // R8: stop the bank
        wr(3'd4, 32'h0);
        quiet_window(100, "R8 no ticks when stopped");
        rd(3'd4, 32'h0, "R8 errors cleared");
        load_ch(2, 7);
        wr(3'd4, 32'h0000_0400);
        expect_period(2, 1, "R8 load ignored while stopped");
        expect_period(1, 1, "R8 ratio reset on restart");

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule